// File: doc/BRIEF.md
# In-Order Retirement Buffer with Flush Recovery

This block keeps every in-flight instruction of an out-of-order core in program order and lets them leave only in that order, so that architectural state is always precise. The front end writes one entry per issued instruction and learns the slot index the entry received. Execution units later refer to that slot when they report completion, a trap, or a wrong branch guess. The entry at the oldest position leaves as soon as it is complete and carries no fault. On leaving, its architectural and physical destination are presented to the rename logic.

When the oldest entry carries a fault, the block redirects fetch to the stored restart address and throws away all speculative work. A mispredicted branch still retires itself and only the entries behind it are discarded. A trapping instruction is discarded together with everything younger. The physical registers of discarded entries are handed back one per cycle, and issue stays closed until that walk ends.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty, `iss_ready` is 1, `iss_idx` is 0, and `cmt_valid`, `rel_valid` and `redir_valid` are 0.
- R2: An accepted issue (`iss_valid` and `iss_ready`) takes slot `iss_idx`. Slots are handed out in ascending order modulo DEPTH, and a flush never rewinds this sequence.
- R3: While DEPTH entries are held, `iss_ready` is 0. An issue offered in a cycle where the buffer is full is refused even if the oldest entry retires in that same cycle.
- R4: A completion on `cmp_idx` marks that slot done. If the slot is the oldest one, `cmt_valid` rises two clock edges after the completion is presented, carrying the entry's destination-valid bit, architectural register, physical register and PC.
- R5: Entries retire at most one per cycle and strictly in issue order, whatever order their completions arrive in.
- R6: A completion, exception or misprediction naming a slot that holds no live entry has no effect. An entry issued into that slot afterwards does not retire until it is completed itself.
- R7: When the oldest entry carries an exception, `redir_valid` pulses with `redir_exc` = 1 and `redir_pc` equal to the address posted with that exception. In that cycle `cmt_valid` is 0, and neither that entry nor any younger entry ever retires.
- R8: When the oldest entry carries a misprediction, `redir_valid` pulses with `redir_exc` = 0 and `redir_pc` equal to the posted target. The branch retires (`cmt_valid` = 1) in the same cycle, and all younger entries are discarded.
- R9: After a redirect, every discarded entry whose destination is valid is reported on `rel_valid`/`rel_preg`, oldest first, one per cycle. No commit occurs during this walk. `iss_ready` is 0 from the redirect cycle until the walk ends.
- R10: If an exception and a misprediction are posted to the same slot in the same cycle, the exception and its address are the ones kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_dst_v | input | 1 | Issued instruction writes a register |
| iss_areg | input | AREG_W | Architectural destination |
| iss_preg | input | PREG_W | Physical destination |
| iss_pc | input | PC_W | Instruction address |
| iss_ready | output | 1 | Issue is accepted this cycle |
| iss_idx | output | log2(DEPTH) | Slot the next issue receives |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | log2(DEPTH) | Completing slot |
| exc_valid | input | 1 | Exception strobe |
| exc_idx | input | log2(DEPTH) | Trapping slot |
| exc_pc | input | PC_W | Handler address for the exception |
| mis_valid | input | 1 | Misprediction strobe |
| mis_idx | input | log2(DEPTH) | Mispredicted branch slot |
| mis_pc | input | PC_W | Correct branch target |
| cmt_valid | output | 1 | Retire strobe (registered) |
| cmt_dst_v | output | 1 | Retired entry writes a register |
| cmt_areg | output | AREG_W | Retired architectural destination |
| cmt_preg | output | PREG_W | Retired physical destination |
| cmt_pc | output | PC_W | Retired instruction address |
| rel_valid | output | 1 | Discarded physical register strobe |
| rel_preg | output | PREG_W | Discarded physical register |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_exc | output | 1 | 1 = exception, 0 = misprediction |
| redir_pc | output | PC_W | Restart address |

## Verification
The bench builds the buffer with DEPTH = 4, a 6-bit physical register field and the default widths. At that depth, all 24 completion orders of a full buffer can be driven in turn, and the pointer wrap bit toggles many times during the run. Every pairing of fill level 1 to 4 with every faulting position and both fault kinds is also within reach, so each flush start point and each walk length is covered. Expected retire and release sequences come from a queue that the bench fills in issue order.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISP = 2'd1,
    CAUSE_EXC  = 2'd2
  } cause_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FLUSH = 1'b1
  } rob_state_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc,
  input  logic                     retire,
  input  logic                     sync_head,
  output logic [$clog2(DEPTH):0]   head_q,
  output logic [$clog2(DEPTH):0]   tail_q,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW:0] FULL_CNT = {1'b1, {IW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc)
        tail_q <= tail_q + 1'b1;
      if (sync_head)
        head_q <= tail_q;
      else if (retire)
        head_q <= head_q + 1'b1;
    end
  end

  assign count = tail_q - head_q;
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
endmodule

// File: rtl/rob_payload.sv
module rob_payload #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [W-1:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [W-1:0]               rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rob_flags.sv
module rob_flags
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmp_we,
  input  logic [$clog2(DEPTH)-1:0]   cmp_idx,
  input  logic                       exc_we,
  input  logic [$clog2(DEPTH)-1:0]   exc_idx,
  input  logic [PC_W-1:0]            exc_pc,
  input  logic                       mis_we,
  input  logic [$clog2(DEPTH)-1:0]   mis_idx,
  input  logic [PC_W-1:0]            mis_pc,
  input  logic                       clr_one,
  input  logic [$clog2(DEPTH)-1:0]   clr_idx,
  input  logic                       clr_all,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic                       rd_ready,
  output cause_e                     rd_cause,
  output logic [PC_W-1:0]            rd_pc
);
  localparam int IW = $clog2(DEPTH);

  logic            rdy_q   [DEPTH];
  cause_e          cause_q [DEPTH];
  logic [PC_W-1:0] rpc_q   [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst || clr_all) begin
        rdy_q[i]   <= 1'b0;
        cause_q[i] <= CAUSE_NONE;
        rpc_q[i]   <= '0;
      end else if (clr_one && clr_idx == IW'(i)) begin
        rdy_q[i]   <= 1'b0;
        cause_q[i] <= CAUSE_NONE;
      end else begin
        if (cmp_we && cmp_idx == IW'(i))
          rdy_q[i] <= 1'b1;
        if (exc_we && exc_idx == IW'(i)) begin
          cause_q[i] <= CAUSE_EXC;
          rpc_q[i]   <= exc_pc;
        end else if (mis_we && mis_idx == IW'(i) && cause_q[i] != CAUSE_EXC) begin
          cause_q[i] <= CAUSE_MISP;
          rpc_q[i]   <= mis_pc;
        end
      end
    end
  end

  assign rd_ready = rdy_q[rd_idx];
  assign rd_cause = cause_q[rd_idx];
  assign rd_pc    = rpc_q[rd_idx];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int PC_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       iss_valid,
  input  logic                       iss_dst_v,
  input  logic [AREG_W-1:0]          iss_areg,
  input  logic [PREG_W-1:0]          iss_preg,
  input  logic [PC_W-1:0]            iss_pc,
  output logic                       iss_ready,
  output logic [$clog2(DEPTH)-1:0]   iss_idx,
  input  logic                       cmp_valid,
  input  logic [$clog2(DEPTH)-1:0]   cmp_idx,
  input  logic                       exc_valid,
  input  logic [$clog2(DEPTH)-1:0]   exc_idx,
  input  logic [PC_W-1:0]            exc_pc,
  input  logic                       mis_valid,
  input  logic [$clog2(DEPTH)-1:0]   mis_idx,
  input  logic [PC_W-1:0]            mis_pc,
  output logic                       cmt_valid,
  output logic                       cmt_dst_v,
  output logic [AREG_W-1:0]          cmt_areg,
  output logic [PREG_W-1:0]          cmt_preg,
  output logic [PC_W-1:0]            cmt_pc,
  output logic                       rel_valid,
  output logic [PREG_W-1:0]          rel_preg,
  output logic                       redir_valid,
  output logic                       redir_exc,
  output logic [PC_W-1:0]            redir_pc
);
  localparam int IW    = $clog2(DEPTH);
  localparam int DST_W = 1 + PREG_W;
  localparam int META_W = AREG_W + PC_W;

  rob_state_e      state_q;
  logic [IW:0]     walk_q;
  logic [IW:0]     head_q, tail_q, cnt;
  logic            full, empty;
  logic            run, alloc;
  logic            start_flush, mis_start, do_retire, walk_done;
  logic            head_ready;
  cause_e          head_cause;
  logic [PC_W-1:0] head_rpc;
  logic [IW-1:0]   head_idx, walk_idx, cmp_off, exc_off, mis_off;
  logic            cmp_live, exc_live, mis_live;
  logic [DST_W-1:0]  dst_head, dst_walk;
  logic [META_W-1:0] meta_head;

  assign run       = (state_q == ST_RUN);
  assign iss_ready = run && !full;
  assign iss_idx   = tail_q[IW-1:0];
  assign alloc     = iss_valid && iss_ready;
  assign head_idx  = head_q[IW-1:0];
  assign walk_idx  = walk_q[IW-1:0];

  // a slot is live when its distance from the head is below the occupancy
  assign cmp_off  = cmp_idx - head_idx;
  assign exc_off  = exc_idx - head_idx;
  assign mis_off  = mis_idx - head_idx;
  assign cmp_live = ({1'b0, cmp_off} < cnt);
  assign exc_live = ({1'b0, exc_off} < cnt);
  assign mis_live = ({1'b0, mis_off} < cnt);

  assign start_flush = run && !empty && (head_cause != CAUSE_NONE);
  assign mis_start   = start_flush && (head_cause == CAUSE_MISP);
  assign do_retire   = run && !empty && head_ready && (head_cause == CAUSE_NONE);
  assign walk_done   = (state_q == ST_FLUSH) && (walk_q == tail_q);

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .alloc     (alloc),
    .retire    (do_retire || mis_start),
    .sync_head (walk_done),
    .head_q    (head_q),
    .tail_q    (tail_q),
    .count     (cnt),
    .full      (full),
    .empty     (empty)
  );

  rob_flags #(.DEPTH(DEPTH), .PC_W(PC_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .cmp_we   (cmp_valid && run && cmp_live),
    .cmp_idx  (cmp_idx),
    .exc_we   (exc_valid && run && exc_live),
    .exc_idx  (exc_idx),
    .exc_pc   (exc_pc),
    .mis_we   (mis_valid && run && mis_live),
    .mis_idx  (mis_idx),
    .mis_pc   (mis_pc),
    .clr_one  (do_retire || mis_start),
    .clr_idx  (head_idx),
    .clr_all  (walk_done),
    .rd_idx   (head_idx),
    .rd_ready (head_ready),
    .rd_cause (head_cause),
    .rd_pc    (head_rpc)
  );

  // destination fields are read at the head (retire) and at the walk pointer (release)
  rob_payload #(.DEPTH(DEPTH), .W(DST_W)) u_dst_head (
    .clk (clk), .we (alloc), .waddr (iss_idx), .wdata ({iss_dst_v, iss_preg}),
    .raddr (head_idx), .rdata (dst_head)
  );

  rob_payload #(.DEPTH(DEPTH), .W(DST_W)) u_dst_walk (
    .clk (clk), .we (alloc), .waddr (iss_idx), .wdata ({iss_dst_v, iss_preg}),
    .raddr (walk_idx), .rdata (dst_walk)
  );

  rob_payload #(.DEPTH(DEPTH), .W(META_W)) u_meta (
    .clk (clk), .we (alloc), .waddr (iss_idx), .wdata ({iss_areg, iss_pc}),
    .raddr (head_idx), .rdata (meta_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      walk_q      <= '0;
      cmt_valid   <= 1'b0;
      cmt_dst_v   <= 1'b0;
      cmt_areg    <= '0;
      cmt_preg    <= '0;
      cmt_pc      <= '0;
      rel_valid   <= 1'b0;
      rel_preg    <= '0;
      redir_valid <= 1'b0;
      redir_exc   <= 1'b0;
      redir_pc    <= '0;
    end else begin
      cmt_valid   <= do_retire || mis_start;
      redir_valid <= start_flush;
      rel_valid   <= 1'b0;
      if (do_retire || mis_start) begin
        cmt_dst_v <= dst_head[DST_W-1];
        cmt_preg  <= dst_head[PREG_W-1:0];
        cmt_areg  <= meta_head[META_W-1:PC_W];
        cmt_pc    <= meta_head[PC_W-1:0];
      end
      if (start_flush) begin
        state_q   <= ST_FLUSH;
        redir_exc <= (head_cause == CAUSE_EXC);
        redir_pc  <= head_rpc;
        walk_q    <= mis_start ? head_q + 1'b1 : head_q;
      end
      if (state_q == ST_FLUSH) begin
        if (walk_done) begin
          state_q <= ST_RUN;
        end else begin
          rel_valid <= dst_walk[DST_W-1];
          rel_preg  <= dst_walk[PREG_W-1:0];
          walk_q    <= walk_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       iss_valid,
  input logic                       iss_ready,
  input logic [$clog2(DEPTH)-1:0]   iss_idx,
  input logic                       cmt_valid,
  input logic                       rel_valid,
  input logic                       redir_valid,
  input logic                       redir_exc,
  input logic [$clog2(DEPTH):0]     cnt
);
  localparam int IW = $clog2(DEPTH);

  assert_idx_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> (iss_idx == ($past(iss_idx) + IW'(1))));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == (IW+1)'(DEPTH)) |-> !iss_ready);

  assert_commit_needs_entry_R4: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> ($past(cnt) != '0));

  assert_exc_no_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && redir_exc) |-> !cmt_valid);

  assert_mis_commits_R8: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !redir_exc) |-> cmt_valid);

  assert_redir_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !iss_ready);

  assert_release_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (!iss_ready && !cmt_valid));
endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_idx     (iss_idx),
  .cmt_valid   (cmt_valid),
  .rel_valid   (rel_valid),
  .redir_valid (redir_valid),
  .redir_exc   (redir_exc),
  .cnt         (cnt)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int CW = 32;
  localparam int EW = 1 + AW + PW + CW;

  logic clk = 1'b0;
  logic rst;
  logic iss_valid, iss_dst_v, iss_ready;
  logic [AW-1:0] iss_areg;
  logic [PW-1:0] iss_preg;
  logic [CW-1:0] iss_pc;
  logic [IW-1:0] iss_idx;
  logic cmp_valid, exc_valid, mis_valid;
  logic [IW-1:0] cmp_idx, exc_idx, mis_idx;
  logic [CW-1:0] exc_pc, mis_pc;
  logic cmt_valid, cmt_dst_v, rel_valid, redir_valid, redir_exc;
  logic [AW-1:0] cmt_areg;
  logic [PW-1:0] cmt_preg, rel_preg;
  logic [CW-1:0] cmt_pc, redir_pc;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int tail_m = 0;
  int flush_cnt = 0;
  logic [EW-1:0] exp_q [$];
  logic [PW-1:0] rel_q [$];
  logic [CW-1:0] exp_rpc;
  logic exp_exc;
  string flag_req = "R7";

  always #5 clk = ~clk;

  rob_core #(.DEPTH(D), .AREG_W(AW), .PREG_W(PW), .PC_W(CW)) dut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_dst_v(iss_dst_v), .iss_areg(iss_areg),
    .iss_preg(iss_preg), .iss_pc(iss_pc), .iss_ready(iss_ready), .iss_idx(iss_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .exc_valid(exc_valid), .exc_idx(exc_idx), .exc_pc(exc_pc),
    .mis_valid(mis_valid), .mis_idx(mis_idx), .mis_pc(mis_pc),
    .cmt_valid(cmt_valid), .cmt_dst_v(cmt_dst_v), .cmt_areg(cmt_areg),
    .cmt_preg(cmt_preg), .cmt_pc(cmt_pc),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .redir_valid(redir_valid), .redir_exc(redir_exc), .redir_pc(redir_pc)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [EW-1:0] mk(input int s);
    logic dv;
    dv = ((s % 3) != 0);
    return {dv, AW'(s % 32), PW'((s * 7 + 1) % 64), CW'(32'h1000 + s * 4)};
  endfunction

  function automatic int fact(input int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  // retire and release monitor: commits are consumed before a redirect is handled
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (cmt_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", {cmt_dst_v, cmt_areg, cmt_preg, cmt_pc}, 0);
        end else begin
          logic [EW-1:0] e;
          e = exp_q.pop_front();
          check({cmt_dst_v, cmt_areg, cmt_preg, cmt_pc} == e, "R5",
                {cmt_dst_v, cmt_areg, cmt_preg, cmt_pc}, e);
        end
      end
      if (redir_valid) begin
        flush_cnt++;
        check(redir_pc == exp_rpc, flag_req, redir_pc, exp_rpc);
        check(redir_exc == exp_exc, flag_req, redir_exc, exp_exc);
        check(!iss_ready, "R9", iss_ready, 0);
        while (exp_q.size() != 0) begin
          logic [EW-1:0] e;
          e = exp_q.pop_front();
          if (e[EW-1]) rel_q.push_back(e[CW +: PW]);
        end
      end
      if (rel_valid) begin
        check(!iss_ready, "R9", iss_ready, 0);
        if (rel_q.size() == 0) begin
          check(1'b0, "R9", rel_preg, 0);
        end else begin
          logic [PW-1:0] p;
          p = rel_q.pop_front();
          check(rel_preg == p, "R9", rel_preg, p);
        end
      end
    end
  end

  task automatic issue(output int slot);
    logic [EW-1:0] e;
    e = mk(seq);
    while (!iss_ready) @(negedge clk);
    check(iss_idx == IW'(tail_m % D), "R2", iss_idx, tail_m % D);
    iss_valid = 1'b1;
    {iss_dst_v, iss_areg, iss_preg, iss_pc} = e;
    slot = int'(iss_idx);
    exp_q.push_back(e);
    tail_m++;
    seq++;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic complete(input int slot);
    cmp_valid = 1'b1;
    cmp_idx = IW'(slot);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!(exp_q.size() == 0 && rel_q.size() == 0 && iss_ready) && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(n < 60, req, n, 60);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sa, sb, s0, dummy;
    rst = 1'b1;
    iss_valid = 0; iss_dst_v = 0; iss_areg = 0; iss_preg = 0; iss_pc = 0;
    cmp_valid = 0; cmp_idx = 0; exc_valid = 0; exc_idx = 0; exc_pc = 0;
    mis_valid = 0; mis_idx = 0; mis_pc = 0;
    exp_rpc = 0; exp_exc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(iss_ready == 1'b1, "R1", iss_ready, 1);
    check(iss_idx == '0, "R1", iss_idx, 0);
    check(cmt_valid == 1'b0, "R1", cmt_valid, 0);
    check(rel_valid == 1'b0, "R1", rel_valid, 0);
    check(redir_valid == 1'b0, "R1", redir_valid, 0);

    // R4: completion-to-commit latency of two edges
    issue(sa);
    complete(sa);
    check(cmt_valid == 1'b0, "R4", cmt_valid, 0);
    @(negedge clk);
    check(cmt_valid == 1'b1, "R4", cmt_valid, 1);
    wait_idle("R4");

    // R3: full buffer refuses issue even with a same-cycle retire
    issue(s0);
    for (int k = 1; k < D; k++) issue(dummy);
    check(iss_ready == 1'b0, "R3", iss_ready, 0);
    iss_valid = 1'b1;
    {iss_dst_v, iss_areg, iss_preg, iss_pc} = mk(999);
    cmp_valid = 1'b1;
    cmp_idx = IW'(s0);
    @(negedge clk);
    cmp_valid = 1'b0;
    @(negedge clk);
    iss_valid = 1'b0;
    check(cmt_valid == 1'b1, "R3", cmt_valid, 1);
    check(iss_idx == IW'(s0), "R3", iss_idx, s0);
    check(iss_ready == 1'b1, "R3", iss_ready, 1);
    for (int k = 1; k < D; k++) complete((s0 + k) % D);
    wait_idle("R3");

    // R6: completion to a free slot is ignored
    issue(sa);
    complete((sa + 1) % D);
    issue(sb);
    check(sb == (sa + 1) % D, "R6", sb, (sa + 1) % D);
    complete(sa);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 1, "R6", exp_q.size(), 1);
    complete(sb);
    wait_idle("R6");

    // R5: every completion order of a full buffer
    for (int p = 0; p < 24; p++) begin
      int sl[4];
      int av[4];
      int f;
      for (int k = 0; k < 4; k++) begin
        av[k] = k;
        issue(sl[k]);
      end
      f = p;
      for (int k = 0; k < 4; k++) begin
        int base;
        int s;
        base = fact(3 - k);
        s = f / base;
        f = f % base;
        complete(sl[av[s]]);
        for (int m = s; m < 3 - k; m++) av[m] = av[m + 1];
      end
      wait_idle("R5");
    end

    // R7 / R8 / R9: every fill level, faulting position and fault kind
    for (int n = 1; n <= D; n++) begin
      for (int j = 0; j < n; j++) begin
        for (int kind = 0; kind < 2; kind++) begin
          int sl[4];
          int fc;
          for (int k = 0; k < n; k++) issue(sl[k]);
          exp_rpc = CW'(32'h8000_0000 + n * 256 + j * 16 + kind);
          exp_exc = (kind == 0);
          flag_req = (kind == 0) ? "R7" : "R8";
          fc = flush_cnt;
          if (kind == 0) begin
            exc_valid = 1'b1; exc_idx = IW'(sl[j]); exc_pc = exp_rpc;
          end else begin
            mis_valid = 1'b1; mis_idx = IW'(sl[j]); mis_pc = exp_rpc;
          end
          @(negedge clk);
          exc_valid = 1'b0;
          mis_valid = 1'b0;
          for (int k = j - 1; k >= 0; k--) complete(sl[k]);
          for (int k = j + 1; k < n; k++) if (k % 2 == 1) complete(sl[k]);
          wait_idle("R9");
          check(flush_cnt == fc + 1, flag_req, flush_cnt, fc + 1);
        end
      end
    end

    // R10: exception beats misprediction posted in the same cycle
    begin
      int fc;
      issue(sa);
      exp_rpc = 32'hDEAD_0000;
      exp_exc = 1'b1;
      flag_req = "R10";
      fc = flush_cnt;
      exc_valid = 1'b1; exc_idx = IW'(sa); exc_pc = 32'hDEAD_0000;
      mis_valid = 1'b1; mis_idx = IW'(sa); mis_pc = 32'hBEEF_0000;
      @(negedge clk);
      exc_valid = 1'b0;
      mis_valid = 1'b0;
      wait_idle("R10");
      check(flush_cnt == fc + 1, "R10", flush_cnt, fc + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule